// File: doc/BRIEF.md
# Load Disambiguation Predictor

This block decides, for every load sent to the memory pipe, whether the load may run ahead of older stores whose addresses are still unresolved. It learns a confidence value per load instruction in a table of small saturating counters. The table is indexed by a folded hash of the load's instruction pointer. A load whose counter is full is allowed to proceed past unknown store addresses. Any other load facing an unknown older store is held back until the scheduler reports that all older store addresses are known and dispatches it again.

Each accepted load takes a slot in a small load buffer. The slot records the address, the age tag and status flags: executed, met-an-unknown-store, bypassed and collided. Every store address that is dispatched later is compared with all held, executed, younger loads. At retirement the counter is trained: it steps up on a clean run and is cleared on a collision. A load that bypassed a store and then collided raises a restart request that names the load. A watchdog counts restarts over fixed windows of retirements. When a window has too many restarts, it turns bypassing off for a fixed number of cycles.

Back-pressure applies only on the load dispatch port (valid/ready). A load is accepted on a cycle with `ld_valid` and `ld_ready` both high, and the decision outputs are valid in that same cycle. `ld_ready` drops only when the retirement port frees the same slot in that cycle. The store, retirement and restart pins are plain single-cycle strobes.

Top module: `ldpred_top`

## Requirements
- R1: The table index is the XOR of successive IDX_W-bit chunks of the instruction pointer (pointer bits [11:6] XOR [5:0] by default). Pointers that fold to the same index share one counter, so pointer 0x041 uses the counter trained by pointer 0x000.
- R2: An accepted load with `ld_unk_older` low gets `dec_go`=1 and `dec_block`=0, whatever its counter holds.
- R3: An accepted load with `ld_unk_older` high whose counter is below its maximum (2^CTR_W-1) gets `dec_block`=1 and `dec_go`=0. The slot remembers that the load met an unknown store across a later dispatch of the same slot.
- R4: An accepted load with `ld_unk_older` high whose counter is at its maximum gets `dec_go`=1 and is marked as having bypassed.
- R5: At retirement, a load that met an unknown store and did not collide increments its counter, saturating at the maximum. From zero, 2^CTR_W-1 such retirements are needed before a bypass is granted.
- R6: A dispatched store marks a held, executed load as collided when the load is younger and the full addresses are equal. This includes a load accepted with go in the same cycle. Age is the AGE_W-bit tag, compared modulo 2^AGE_W, so a load with tag 2 is younger than a store with tag 62. A younger store, or a store to a different address, leaves the load unmarked.
- R7: Retiring a collided load clears its counter to zero, even if that load never bypassed.
- R8: Retiring a load that both bypassed and collided raises `rs_valid` for one cycle on the next clock edge, with that load's slot on `rs_slot` and its tag on `rs_tag`. Any other retirement leaves `rs_valid` low.
- R9: Retirements are counted in windows of WIN. If the restarts inside a window exceed `wd_thresh`, bypassing is disabled for OFF_CYC cycles, starting after the window's last retirement. While disabled, every load that meets an unknown store is blocked. A count equal to the threshold does not disable.
- R10: `ld_ready` is low exactly when `rt_valid` is high and `rt_slot` equals `ld_slot`. Otherwise it is high.
- R11: After reset all counters are zero, the load buffer is empty, the watchdog is enabled and `rs_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load dispatch request |
| ld_ready | output | 1 | Load dispatch can be accepted |
| ld_slot | input | SLOT_W | Load buffer slot of the load |
| ld_ip | input | IP_W | Instruction pointer of the load |
| ld_addr | input | AW | Load address |
| ld_tag | input | AGE_W | Program-order age tag of the load |
| ld_unk_older | input | 1 | An older store with unknown address exists |
| dec_go | output | 1 | Load may execute now |
| dec_block | output | 1 | Load is held back |
| st_valid | input | 1 | Store address dispatch strobe |
| st_addr | input | AW | Store address |
| st_tag | input | AGE_W | Age tag of the store |
| rt_valid | input | 1 | Load retirement strobe |
| rt_slot | input | SLOT_W | Slot of the retiring load |
| wd_thresh | input | TH_W | Restart count per window that may not be exceeded |
| rs_valid | output | 1 | Pipeline restart request |
| rs_slot | output | SLOT_W | Slot of the load to restart from |
| rs_tag | output | AGE_W | Age tag of the load to restart from |

## Verification
The bench builds the block with CTR_W=2, so a counter saturates after three clean retirements and learning, bypass and clearing can all be reached in a few dozen cycles. WIN=16 and OFF_CYC=64 make a full watchdog window short enough to sequence by hand. The bench can then run one window that sits exactly at the threshold, a second window that exceeds it, and the whole disabled period up to re-enable. The default pointer, tag and address widths are kept, so the hash aliasing and the age-tag wrap are exercised at their real sizes.

// File: rtl/ldpred_pkg.sv
package ldpred_pkg;

  typedef struct packed {
    logic vld;   // slot holds a load
    logic exe;   // load has executed
    logic upd;   // load met an unknown older store
    logic byp;   // load bypassed an unknown store
    logic col;   // an older store hit the load's address
  } lb_flags_t;

endpackage

// File: rtl/ldpred_table.sv
module ldpred_table #(
  parameter int IP_W  = 12,
  parameter int IDX_W = 6,
  parameter int CTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IP_W-1:0]  rd_ip,
  output logic [IDX_W-1:0] rd_idx,
  output logic             rd_sat,
  input  logic             up_inc,
  input  logic             up_clr,
  input  logic [IDX_W-1:0] up_idx
);
  localparam int ENT   = 1 << IDX_W;
  localparam int NCH   = (IP_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;
  localparam logic [CTR_W-1:0] MAX = {CTR_W{1'b1}};

  logic [CTR_W-1:0] ctr_q [ENT];
  logic [CTR_W-1:0] cur_ctr;
  logic [PAD_W-1:0] ip_ext;

  assign ip_ext = PAD_W'(rd_ip);

  always_comb begin
    rd_idx = '0;
    for (int k = 0; k < NCH; k++) rd_idx = rd_idx ^ ip_ext[k*IDX_W +: IDX_W];
  end

  assign rd_sat  = (ctr_q[rd_idx] == MAX);
  assign cur_ctr = ctr_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENT; e++) ctr_q[e] <= '0;
    end else if (up_clr) begin
      ctr_q[up_idx] <= '0;
    end else if (up_inc && cur_ctr != MAX) begin
      ctr_q[up_idx] <= cur_ctr + 1'b1;
    end
  end

  // R7
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_clr |=> ctr_q[$past(up_idx)] == '0);

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_inc && !up_clr && cur_ctr != MAX) |=> ctr_q[$past(up_idx)] == $past(cur_ctr) + 1'b1);

  // R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_inc && !up_clr && cur_ctr == MAX) |=> ctr_q[$past(up_idx)] == MAX);

endmodule

// File: rtl/ldpred_lbuf.sv
module ldpred_lbuf
  import ldpred_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AGE_W = 6,
  parameter int AW    = 32,
  parameter int IDX_W = 6,
  parameter int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_acc,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [AW-1:0]     ld_addr,
  input  logic [AGE_W-1:0]  ld_tag,
  input  logic              ld_unk,
  input  logic              ld_go,
  input  logic              ld_byp,
  input  logic              st_valid,
  input  logic [AW-1:0]     st_addr,
  input  logic [AGE_W-1:0]  st_tag,
  input  logic              rt_valid,
  input  logic [SLOT_W-1:0] rt_slot,
  output logic              rt_hit,
  output logic [IDX_W-1:0]  rt_idx,
  output logic              rt_inc,
  output logic              rt_clr,
  output logic              rs_now,
  output logic              rs_valid,
  output logic [SLOT_W-1:0] rs_slot,
  output logic [AGE_W-1:0]  rs_tag
);
  lb_flags_t        fl_q   [DEPTH];
  logic [AW-1:0]    addr_q [DEPTH];
  logic [AGE_W-1:0] tag_q  [DEPTH];
  logic [IDX_W-1:0] idx_q  [DEPTH];
  logic [DEPTH-1:0] held_hit;
  logic             new_hit;

  function automatic logic is_younger(input logic [AGE_W-1:0] ld_t, input logic [AGE_W-1:0] st_t);
    logic [AGE_W-1:0] d;
    d = ld_t - st_t;
    return (d != '0) && !d[AGE_W-1];
  endfunction

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_cmp
      assign held_hit[e] = st_valid && fl_q[e].vld && fl_q[e].exe &&
                           is_younger(tag_q[e], st_tag) && (addr_q[e] == st_addr);
    end
  endgenerate

  assign new_hit = st_valid && ld_acc && ld_go && is_younger(ld_tag, st_tag) && (ld_addr == st_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        fl_q[i]   <= '0;
        addr_q[i] <= '0;
        tag_q[i]  <= '0;
        idx_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (rt_valid && rt_slot == SLOT_W'(i)) begin
          fl_q[i] <= '0;
        end else if (ld_acc && ld_slot == SLOT_W'(i)) begin
          fl_q[i].vld <= 1'b1;
          addr_q[i]   <= ld_addr;
          tag_q[i]    <= ld_tag;
          idx_q[i]    <= ld_idx;
          if (fl_q[i].vld) begin
            fl_q[i].exe <= fl_q[i].exe | ld_go;
            fl_q[i].upd <= fl_q[i].upd | ld_unk;
            fl_q[i].byp <= fl_q[i].byp | ld_byp;
            fl_q[i].col <= fl_q[i].col | held_hit[i] | new_hit;
          end else begin
            fl_q[i].exe <= ld_go;
            fl_q[i].upd <= ld_unk;
            fl_q[i].byp <= ld_byp;
            fl_q[i].col <= new_hit;
          end
        end else if (held_hit[i]) begin
          fl_q[i].col <= 1'b1;
        end
      end
    end
  end

  assign rt_hit = rt_valid && fl_q[rt_slot].vld;
  assign rt_idx = idx_q[rt_slot];
  assign rt_clr = rt_hit && fl_q[rt_slot].col;
  assign rt_inc = rt_hit && fl_q[rt_slot].upd && !fl_q[rt_slot].col;
  assign rs_now = rt_hit && fl_q[rt_slot].byp && fl_q[rt_slot].col;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_slot  <= '0;
      rs_tag   <= '0;
    end else begin
      rs_valid <= rs_now;
      if (rs_now) begin
        rs_slot <= rt_slot;
        rs_tag  <= tag_q[rt_slot];
      end
    end
  end

  // R8
  rs_after_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $past(rt_valid));

  // R8
  rs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |=> !rs_valid || $past(rt_valid));

  // R6
  col_needs_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_valid && !ld_acc) |=> $stable(fl_q[0].col) || $past(rt_valid));

endmodule

// File: rtl/ldpred_wdog.sv
module ldpred_wdog #(
  parameter int WIN     = 256,
  parameter int OFF_CYC = 4096,
  parameter int TH_W    = $clog2(WIN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rt_evt,
  input  logic            rs_evt,
  input  logic [TH_W-1:0] thresh,
  output logic            dis_off
);
  localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int OFF_W = $clog2(OFF_CYC + 1);

  logic [WIN_W-1:0] win_q;
  logic [TH_W-1:0]  hits_q;
  logic [OFF_W-1:0] off_q;
  logic [TH_W:0]    hits_nx;
  logic             last, trip;

  assign hits_nx = {1'b0, hits_q} + (TH_W+1)'(rs_evt);
  assign last    = rt_evt && (win_q == WIN_W'(WIN - 1));
  assign trip    = last && (hits_nx > {1'b0, thresh});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q  <= '0;
      hits_q <= '0;
      off_q  <= '0;
    end else begin
      if (last) begin
        win_q  <= '0;
        hits_q <= '0;
      end else if (rt_evt) begin
        win_q  <= win_q + 1'b1;
        hits_q <= hits_nx[TH_W-1:0];
      end
      if (trip)             off_q <= OFF_W'(OFF_CYC);
      else if (off_q != '0) off_q <= off_q - 1'b1;
    end
  end

  assign dis_off = (off_q != '0);

  // R9
  off_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dis_off) |-> $past(rt_evt));

  // R9
  off_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_off && !trip) |=> off_q == $past(off_q) - 1'b1);

endmodule

// File: rtl/ldpred_top.sv
module ldpred_top #(
  parameter int IP_W    = 12,
  parameter int IDX_W   = 6,
  parameter int CTR_W   = 4,
  parameter int DEPTH   = 8,
  parameter int AGE_W   = 6,
  parameter int AW      = 32,
  parameter int WIN     = 256,
  parameter int OFF_CYC = 4096,
  parameter int SLOT_W  = $clog2(DEPTH),
  parameter int TH_W    = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [SLOT_W-1:0] ld_slot,
  input  logic [IP_W-1:0]   ld_ip,
  input  logic [AW-1:0]     ld_addr,
  input  logic [AGE_W-1:0]  ld_tag,
  input  logic              ld_unk_older,
  output logic              dec_go,
  output logic              dec_block,
  input  logic              st_valid,
  input  logic [AW-1:0]     st_addr,
  input  logic [AGE_W-1:0]  st_tag,
  input  logic              rt_valid,
  input  logic [SLOT_W-1:0] rt_slot,
  input  logic [TH_W-1:0]   wd_thresh,
  output logic              rs_valid,
  output logic [SLOT_W-1:0] rs_slot,
  output logic [AGE_W-1:0]  rs_tag
);
  logic [IDX_W-1:0] rd_idx, rt_idx;
  logic rd_sat, allowed, acc;
  logic rt_hit, rt_inc, rt_clr, rs_now, dis_off;

  assign ld_ready  = !(rt_valid && rt_slot == ld_slot);
  assign acc       = ld_valid && ld_ready;
  assign allowed   = rd_sat && !dis_off;
  assign dec_go    = acc && (!ld_unk_older || allowed);
  assign dec_block = acc && ld_unk_older && !allowed;

  ldpred_table #(.IP_W(IP_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) u_tab (
    .clk(clk), .rst_n(rst_n), .rd_ip(ld_ip), .rd_idx(rd_idx), .rd_sat(rd_sat),
    .up_inc(rt_inc), .up_clr(rt_clr), .up_idx(rt_idx)
  );

  ldpred_lbuf #(.DEPTH(DEPTH), .AGE_W(AGE_W), .AW(AW), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_lb (
    .clk(clk), .rst_n(rst_n), .ld_acc(acc), .ld_slot(ld_slot), .ld_idx(rd_idx),
    .ld_addr(ld_addr), .ld_tag(ld_tag), .ld_unk(ld_unk_older), .ld_go(dec_go),
    .ld_byp(dec_go && ld_unk_older), .st_valid(st_valid), .st_addr(st_addr),
    .st_tag(st_tag), .rt_valid(rt_valid), .rt_slot(rt_slot), .rt_hit(rt_hit),
    .rt_idx(rt_idx), .rt_inc(rt_inc), .rt_clr(rt_clr), .rs_now(rs_now),
    .rs_valid(rs_valid), .rs_slot(rs_slot), .rs_tag(rs_tag)
  );

  ldpred_wdog #(.WIN(WIN), .OFF_CYC(OFF_CYC), .TH_W(TH_W)) u_wd (
    .clk(clk), .rst_n(rst_n), .rt_evt(rt_hit), .rs_evt(rs_now),
    .thresh(wd_thresh), .dis_off(dis_off)
  );

  // R2
  dec_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_go && dec_block));

  // R3
  block_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_block |-> ld_unk_older && ld_valid);

  // R9
  off_no_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_off && ld_valid && ld_unk_older) |-> !dec_go);

  // R10
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ready |-> rt_valid);

endmodule

// File: tb/ldpred_top_tb_top.sv
module ldpred_top_tb_top;
  localparam int CLK_PER = 10;
  localparam int WIN = 16;
  localparam int OFF_CYC = 64;
  localparam int TH_W = $clog2(WIN + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, ld_unk_older = 1'b0, st_valid = 1'b0, rt_valid = 1'b0;
  logic [2:0] ld_slot = '0, rt_slot = '0;
  logic [11:0] ld_ip = '0;
  logic [31:0] ld_addr = '0, st_addr = '0;
  logic [5:0] ld_tag = '0, st_tag = '0;
  logic [TH_W-1:0] wd_thresh = '1;
  logic ld_ready, dec_go, dec_block, rs_valid;
  logic [2:0] rs_slot;
  logic [5:0] rs_tag;

  int total = 0;
  int bad = 0;
  logic [5:0] tg = 6'd0;

  always #(CLK_PER/2) clk = ~clk;

  ldpred_top #(.CTR_W(2), .WIN(WIN), .OFF_CYC(OFF_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_slot(ld_slot), .ld_ip(ld_ip), .ld_addr(ld_addr), .ld_tag(ld_tag),
    .ld_unk_older(ld_unk_older), .dec_go(dec_go), .dec_block(dec_block),
    .st_valid(st_valid), .st_addr(st_addr), .st_tag(st_tag), .rt_valid(rt_valid),
    .rt_slot(rt_slot), .wd_thresh(wd_thresh), .rs_valid(rs_valid),
    .rs_slot(rs_slot), .rs_tag(rs_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_ld(input logic [2:0] s, input logic [11:0] ip, input logic [31:0] a,
                          input logic [5:0] t, input logic u, output logic go, output logic blk);
    ld_valid = 1'b1; ld_slot = s; ld_ip = ip; ld_addr = a; ld_tag = t; ld_unk_older = u;
    #1;
    go = dec_go; blk = dec_block;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0; ld_unk_older = 1'b0;
  endtask

  task automatic drive_st(input logic [31:0] a, input logic [5:0] t);
    st_valid = 1'b1; st_addr = a; st_tag = t;
    @(posedge clk);
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic retire(input logic [2:0] s, output logic rv, output logic [2:0] rsl, output logic [5:0] rtg);
    rt_valid = 1'b1; rt_slot = s;
    @(posedge clk);
    #1;
    rv = rs_valid; rsl = rs_slot; rtg = rs_tag;
    @(negedge clk);
    rt_valid = 1'b0;
  endtask

  // one load on slot 7 that meets an unknown store, then retires cleanly
  task automatic probe(input logic [11:0] ip, input logic exp_go, input string req);
    logic go, blk, rv; logic [2:0] rsl; logic [5:0] rtg;
    tg = tg + 6'd2;
    drive_ld(3'd7, ip, 32'h0000_8000, tg, 1'b1, go, blk);
    chk(go == exp_go && blk == !exp_go, req, int'(go), int'(exp_go));
    if (!go) drive_ld(3'd7, ip, 32'h0000_8000, tg, 1'b0, go, blk);
    retire(3'd7, rv, rsl, rtg);
  endtask

  task automatic pad();
    logic go, blk, rv; logic [2:0] rsl; logic [5:0] rtg;
    tg = tg + 6'd2;
    drive_ld(3'd7, 12'hfff, 32'h0000_9000, tg, 1'b0, go, blk);
    retire(3'd7, rv, rsl, rtg);
  endtask

  // load on slot 1, then a store, then retirement
  task automatic collide(input logic [11:0] ip, input logic [5:0] lt, input logic [5:0] stt,
                         input logic same, input logic exp_go, input logic exp_rs, input string req);
    logic go, blk, rv; logic [2:0] rsl; logic [5:0] rtg;
    drive_ld(3'd1, ip, 32'h0000_4440, lt, 1'b1, go, blk);
    chk(go == exp_go, req, int'(go), int'(exp_go));
    if (!go) drive_ld(3'd1, ip, 32'h0000_4440, lt, 1'b0, go, blk);
    drive_st(same ? 32'h0000_4440 : 32'h0000_4444, stt);
    retire(3'd1, rv, rsl, rtg);
    chk(rv == exp_rs, {req, " restart"}, int'(rv), int'(exp_rs));
    if (exp_rs) chk(rsl == 3'd1 && rtg == lt, {req, " restart id"}, int'(rtg), int'(lt));
  endtask

  task automatic t_reset();
    chk(rs_valid == 1'b0, "R11 rs_valid", int'(rs_valid), 0);
    chk(ld_ready == 1'b1, "R11 ld_ready", int'(ld_ready), 1);
  endtask

  task automatic t_plain();
    logic go, blk, rv; logic [2:0] rsl; logic [5:0] rtg;
    drive_ld(3'd0, 12'h123, 32'h100, 6'd1, 1'b0, go, blk);
    chk(go && !blk, "R2 no unknown store", int'(go), 1);
    retire(3'd0, rv, rsl, rtg);
    chk(!rv, "R8 plain retire", int'(rv), 0);
  endtask

  task automatic t_learn();
    probe(12'h010, 1'b0, "R3 cold block 1");
    probe(12'h010, 1'b0, "R3 cold block 2");
    probe(12'h010, 1'b0, "R5 block before sat");
    probe(12'h010, 1'b1, "R4 R5 go when saturated");
  endtask

  task automatic t_restart();
    collide(12'h010, 6'd20, 6'd19, 1'b1, 1'b1, 1'b1, "R8 bypass collide");
    probe(12'h010, 1'b0, "R7 cleared after restart");
  endtask

  task automatic t_no_hit();
    probe(12'h010, 1'b0, "R5 relearn 2");
    probe(12'h010, 1'b0, "R5 relearn 3");
    collide(12'h010, 6'd30, 6'd31, 1'b1, 1'b1, 1'b0, "R6 younger store");
    probe(12'h010, 1'b1, "R6 counter kept");
    collide(12'h010, 6'd40, 6'd39, 1'b0, 1'b1, 1'b0, "R6 other address");
    probe(12'h010, 1'b1, "R6 counter kept 2");
  endtask

  task automatic t_wrap();
    collide(12'h010, 6'd2, 6'd62, 1'b1, 1'b1, 1'b1, "R6 tag wrap");
  endtask

  task automatic t_clear_nobyp();
    probe(12'h010, 1'b0, "R7 train 1");
    probe(12'h010, 1'b0, "R7 train 2");
    collide(12'h010, 6'd50, 6'd49, 1'b1, 1'b0, 1'b0, "R7 blocked collide");
    probe(12'h010, 1'b0, "R7 after clear 1");
    probe(12'h010, 1'b0, "R7 after clear 2");
    probe(12'h010, 1'b0, "R7 after clear 3");
    probe(12'h010, 1'b1, "R7 after clear 4");
  endtask

  task automatic t_alias();
    probe(12'h000, 1'b0, "R1 train a");
    probe(12'h000, 1'b0, "R1 train b");
    probe(12'h000, 1'b0, "R1 train c");
    probe(12'h041, 1'b1, "R1 aliased go");
    probe(12'h002, 1'b0, "R1 distinct index");
  endtask

  task automatic t_ready();
    rt_valid = 1'b1; rt_slot = 3'd5; ld_slot = 3'd5;
    #1;
    chk(ld_ready == 1'b0, "R10 same slot", int'(ld_ready), 0);
    ld_slot = 3'd6;
    #1;
    chk(ld_ready == 1'b1, "R10 other slot", int'(ld_ready), 1);
    rt_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_wdog();
    do_reset();
    tg = 6'd0;
    wd_thresh = TH_W'(1);
    probe(12'h010, 1'b0, "R11 counter zero");      // r1
    probe(12'h010, 1'b0, "R9 train A");            // r2
    probe(12'h010, 1'b0, "R9 train A");            // r3
    for (int i = 0; i < 3; i++) probe(12'h020, 1'b0, "R9 train E");  // r4-6
    probe(12'h020, 1'b1, "R9 E ready");            // r7
    for (int i = 0; i < 3; i++) probe(12'h030, 1'b0, "R9 train C");  // r8-10
    for (int i = 0; i < 3; i++) probe(12'h035, 1'b0, "R9 train D");  // r11-13
    collide(12'h010, 6'd20, 6'd19, 1'b1, 1'b1, 1'b1, "R9 window1 restart"); // r14
    probe(12'h020, 1'b1, "R9 E go");               // r15
    probe(12'h020, 1'b1, "R9 E go");               // r16, equal to threshold
    collide(12'h030, 6'd30, 6'd29, 1'b1, 1'b1, 1'b1, "R9 no trip at equal"); // r17
    collide(12'h020, 6'd40, 6'd39, 1'b1, 1'b1, 1'b1, "R9 window2 restart"); // r18
    for (int i = 0; i < 14; i++) pad();            // r19-32, trip
    probe(12'h035, 1'b0, "R9 disabled");
    repeat (OFF_CYC) @(negedge clk);
    probe(12'h035, 1'b1, "R9 re-enabled");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_plain();
    t_learn();
    t_restart();
    t_no_hit();
    t_wrap();
    t_clear_nobyp();
    t_alias();
    t_ready();
    t_wdog();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule